// File: doc/BRIEF.md
# Bfloat16 Subtraction Result Normalizer

This block is the normalization stage that sits after the mantissa subtractor of a bfloat16 adder. When two operands of opposite sign are combined, the 8-bit result mantissa can lose its leading one, so the hidden bit no longer sits in the top position. The block counts the leading zeros of that mantissa with a staged halving search. It then moves the mantissa left by that count in one step and lowers the working exponent by the same amount. No bit-by-bit iteration takes place, so the latency is the same for every input.

A result whose mantissa is zero, or whose exponent would reach zero or below, is flushed to positive zero. No denormal is produced. The output is a packed bfloat16 word, registered once, and it comes with a valid strobe. Operand alignment, the subtraction itself, rounding and special values belong to other stages.

Top module: `bf16_norm_stage`

## Requirements
- R1: While rst_n is low and after reset, out_valid is 0 and out_word is 0x0000.
- R2: out_valid is 1 in exactly the cycle after a cycle with in_valid at 1, and 0 otherwise. The result for an input appears on out_word in that same cycle.
- R3: An in_mant of zero gives out_word 0x0000, whatever the sign and exponent.
- R4: The shift amount is the number of leading zeros of in_mant within its 8 bits. out_word[6:0] is the low 7 bits of the mantissa after a left shift by that amount. The hidden bit, bit 7 after the shift, is dropped.
- R5: For a result that is not flushed, out_word[14:7] is in_exp minus the shift amount.
- R6: When in_exp, read as two's complement, is less than or equal to the shift amount, out_word is 0x0000. This holds for zero and negative exponents too.
- R7: For a result that is not flushed, out_word[15] equals in_sign.
- R8: In a cycle that follows one with in_valid at 0, out_word keeps its previous value.
- R9: A mantissa with bit 7 already set passes through with a shift of zero and an unchanged exponent, provided in_exp is above zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input qualifier |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | EXP_W (10) | Working exponent, two's complement |
| in_mant | input | MANT_W (8) | Result mantissa, hidden one expected at the top bit |
| out_valid | output | 1 | Result qualifier, one cycle after in_valid |
| out_word | output | 16 | Packed bfloat16: sign [15], exponent [14:7], fraction [6:0] |

## Verification
The bench builds the block with its defaults: an 8-bit mantissa, which gives a three-stage search of 4, 2 and 1 bits, and a 10-bit signed working exponent. These values let the bench cover all 256 mantissas. For each mantissa it uses exponents that are negative, zero, one, equal to the shift amount and just above it, so every flush boundary is reached. Random idle gaps test the strobe timing and the hold behaviour. Random sign and exponent pairs are compared against a model that shifts one bit at a time.

// File: rtl/bfn_pkg.sv
package bfn_pkg;

   localparam int BF_EXP_W  = 8;
   localparam int BF_FRAC_W = 7;
   localparam int BF_WORD_W = 1 + BF_EXP_W + BF_FRAC_W;

   typedef struct packed {
      logic                 sign;
      logic [BF_EXP_W-1:0]  expo;
      logic [BF_FRAC_W-1:0] frac;
   } bf16_word_t;

   localparam bf16_word_t BF_POS_ZERO = '0;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/bfn_lzc.sv
module bfn_lzc #(
   parameter int W      = 8,
   localparam int STAGES = $clog2(W),
   localparam int CNT_W  = STAGES + 1
) (
   input  logic [W-1:0]     value,
   output logic [CNT_W-1:0] count,
   output logic             all_zero,
   output logic [W-1:0]     aligned
);

   logic [STAGES:0][W-1:0]     xs;
   logic [STAGES:0][CNT_W-1:0] cs;

   assign xs[0] = value;
   assign cs[0] = '0;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam int PW = W >> (s + 1);
      logic upper_zero;
      assign upper_zero = (xs[s][W-1 -: PW] == '0);
      assign xs[s+1]    = upper_zero ? (xs[s] << PW) : xs[s];
      assign cs[s+1]    = upper_zero ? (cs[s] + CNT_W'(PW)) : cs[s];
   end

   assign all_zero = (value == '0);
   assign count    = all_zero ? CNT_W'(W) : cs[STAGES];
   assign aligned  = xs[STAGES];

   // R4: the staged search leaves a nonzero value with its top bit set
   always_comb begin
      if (!all_zero) begin
         a_r4_aligned_msb: assert (aligned[W-1]);
         a_r4_count_range: assert (count < CNT_W'(W));
      end
   end

endmodule

// File: rtl/bfn_adjust.sv
module bfn_adjust #(
   parameter int MANT_W = 8,
   parameter int EXP_W  = 10,
   parameter int CNT_W  = 4
) (
   input  logic [EXP_W-1:0]  exp_in,
   input  logic [CNT_W-1:0]  shift,
   input  logic              mant_zero,
   output logic              flush,
   output logic [EXP_W-1:0]  exp_out
);

   logic signed [EXP_W-1:0] exp_s;
   logic signed [EXP_W-1:0] shift_s;
   logic                    under;

   assign exp_s   = signed'(exp_in);
   assign shift_s = signed'(EXP_W'(shift));
   assign under   = (exp_s <= shift_s);
   assign flush   = mant_zero | under;
   assign exp_out = EXP_W'(exp_s - shift_s);

   // R6: a result that survives keeps a strictly positive exponent
   always_comb begin
      if (!flush) begin
         a_r6_positive_exp: assert (signed'(exp_out) > 0);
      end
   end

endmodule

// File: rtl/bf16_norm_stage.sv
module bf16_norm_stage #(
   parameter int MANT_W = 8,
   parameter int EXP_W  = 10,
   localparam int CNT_W  = $clog2(MANT_W) + 1,
   localparam int WORD_W = bfn_pkg::BF_WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sign,
   input  logic [EXP_W-1:0]  in_exp,
   input  logic [MANT_W-1:0] in_mant,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word
);
   import bfn_pkg::*;

   if (!is_pow2(MANT_W) || MANT_W < 2) begin : g_bad_mant
      $error("MANT_W must be a power of two of at least 2");
   end
   if (MANT_W != BF_FRAC_W + 1) begin : g_bad_frac
      $error("MANT_W must match the bfloat16 fraction plus hidden bit");
   end
   if (EXP_W <= BF_EXP_W) begin : g_bad_exp
      $error("EXP_W needs a sign bit above the packed exponent field");
   end

   logic [CNT_W-1:0]  lz_count;
   logic              lz_zero;
   logic [MANT_W-1:0] lz_aligned;
   logic              adj_flush;
   logic [EXP_W-1:0]  adj_exp;
   bf16_word_t        next_word;
   bf16_word_t        word_q;
   logic              valid_q;

   bfn_lzc #(.W(MANT_W)) u_lzc (
      .value    (in_mant),
      .count    (lz_count),
      .all_zero (lz_zero),
      .aligned  (lz_aligned)
   );

   bfn_adjust #(.MANT_W(MANT_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_adjust (
      .exp_in    (in_exp),
      .shift     (lz_count),
      .mant_zero (lz_zero),
      .flush     (adj_flush),
      .exp_out   (adj_exp)
   );

   always_comb begin
      if (adj_flush) begin
         next_word = BF_POS_ZERO;
      end else begin
         next_word.sign = in_sign;
         next_word.expo = adj_exp[BF_EXP_W-1:0];
         next_word.frac = lz_aligned[BF_FRAC_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         word_q  <= BF_POS_ZERO;
      end else begin
         valid_q <= in_valid;
         if (in_valid) begin
            word_q <= next_word;
         end
      end
   end

   assign out_valid = valid_q;
   assign out_word  = word_q;

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r3_zero_mant: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mant == '0) |=> (out_word == '0));
   a_r6_nonpos_exp: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && signed'(in_exp) <= 0) |=> (out_word == '0));
   a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_word));
   a_r5_nonzero_has_exp: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_word != '0) |-> (out_word[14:7] != '0));

endmodule

// File: tb/bf16_norm_stage_bench.sv
module bf16_norm_stage_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_sign = 1'b0;
   logic [9:0] in_exp = '0;
   logic [7:0] in_mant = '0;
   logic       out_valid;
   logic [15:0] out_word;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   bit          pend_valid = 0;
   logic [15:0] pend_word  = '0;
   logic [15:0] held_word  = '0;
   string       pend_tag   = "R1";
   bit          pend_fields = 0;
   bit          pend_sign  = 0;
   int          pend_exp   = 0;
   int          pend_frac  = 0;

   always #5 clk = ~clk;

   bf16_norm_stage u_bf16_norm_stage (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
      .in_exp(in_exp), .in_mant(in_mant), .out_valid(out_valid), .out_word(out_word)
   );

   function automatic int lz8(input int m);
      int n = 0;
      for (int b = 7; b >= 0; b--) begin
         if (m[b]) return n;
         n++;
      end
      return n;
   endfunction

   // bit-serial reference: shift one place at a time, then flush if exponent not positive
   function automatic logic [15:0] ref_norm(input bit s, input int e, input int m);
      if (m == 0) return 16'h0000;
      while ((m & 'h80) == 0) begin
         m = (m << 1) & 'hFF;
         e = e - 1;
      end
      if (e <= 0) return 16'h0000;
      return {s, 8'(e), 7'(m)};
   endfunction

   function automatic string tag_for(input int e, input int m);
      if (m == 0) return "R3";
      if (e <= lz8(m)) return "R6";
      if (m[7]) return "R9";
      return "R5";
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic settle_pending();
      check(out_valid == pend_valid, "R2", out_valid, pend_valid);
      if (pend_valid) begin
         check(out_word == pend_word, pend_tag, out_word, pend_word);
         if (pend_fields) begin
            check(out_word[6:0] == 7'(pend_frac), "R4", out_word[6:0], pend_frac);
            check(out_word[14:7] == 8'(pend_exp), "R5", out_word[14:7], pend_exp);
            check(out_word[15] == pend_sign, "R7", out_word[15], pend_sign);
         end
         held_word = pend_word;
      end else begin
         check(out_word == held_word, "R8", out_word, held_word);
      end
   endtask

   task automatic step(input bit v, input bit s, input int e, input int m);
      @(negedge clk);
      settle_pending();
      in_valid = v;
      in_sign  = s;
      in_exp   = 10'(e);
      in_mant  = 8'(m);
      pend_valid  = v;
      pend_word   = ref_norm(s, e, m);
      pend_tag    = tag_for(e, m);
      pend_fields = v && (pend_word != 0);
      pend_sign   = s;
      pend_exp    = e - lz8(m);
      pend_frac   = (m << lz8(m)) & 'h7F;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      int seed;
      seed = 32'h5A17;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1", out_valid, 0);
      check(out_word == 16'h0000, "R1", out_word, 0);
      @(negedge clk);
      rst_n = 1'b1;
      check(out_valid == 1'b0, "R1", out_valid, 0);

      // directed corners
      step(1, 1, 200, 0);      // R3 zero mantissa
      step(1, 0, 5, 8'h80);    // R9 already normalized
      step(1, 1, 0, 8'hC3);    // R6 zero exponent, no shift
      step(1, 0, 1, 8'h01);    // R6 exponent below shift
      step(1, 1, 7, 8'h01);    // R6 exponent equal to shift
      step(1, 1, 8, 8'h01);    // R5 exponent one above shift
      step(0, 0, 0, 0);        // R8 idle hold
      step(0, 1, 99, 8'h44);   // R8 idle with live-looking inputs
      step(1, 0, -3, 8'h10);   // R6 negative exponent

      // every mantissa against a spread of exponents
      for (int m = 0; m < 256; m++) begin
         int lz;
         lz = lz8(m);
         step(1, m[0], -5, m);
         step(1, m[1], 0, m);
         step(1, m[2], 1, m);
         step(1, m[3], lz, m);
         step(1, m[4], lz + 1, m);
         step(1, m[5], lz + 2, m);
         step(1, m[6], 127, m);
         step(1, m[7], 255, m);
         if (($urandom() % 4) == 0) step(0, 0, 0, 0);
      end

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int e;
         e = int'($urandom() % 270) - 12;
         if (e > 255) e = 255;
         step(($urandom() % 5) != 0, $urandom() % 2, e, $urandom() % 256);
      end

      step(0, 0, 0, 0);
      @(negedge clk);
      settle_pending();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule